// File: doc/BRIEF.md
# Triggered Waveform Update Sequencer

This block paces the playback of a stored sample pattern to one group of output converters. An accepted start trigger begins a programmable start delay. The start delay counts enable pulses of a separately chosen delay clock. When the delay ends, the sequencer reads the circular pattern memory at a fixed update interval, using timebase cycles. It groups samples into waveforms of a programmed length and repeats the waveform a programmed number of times. An optional idle gap separates consecutive waveforms.

If a waveform is shorter than the stored pattern, each repetition plays the next slice. If it is longer, the read pointer wraps. Every sample produces a one-cycle write strobe, and that strobe is routed to each enabled channel. The group-update pulse in the following cycle then loads all enabled channels at once. A stop trigger ends playback in one of three ways. A trigger counter caps how many starts are honoured until software clears it.

Top module: `wfg_seq`

## Requirements
- R1: While reset is high and after it is released, `wr_stb`, `ch_wr`, `group_upd` and `busy` are 0 and `rd_addr` is 0, until a start trigger is accepted.
- R2: A start trigger is taken on the clock edge that samples it in cycle T. With `start_delay` = D, the first strobe appears in cycle T+D when `dly_tick` is held high, or in cycle T if D is 0. Only cycles with `dly_tick` high count toward D.
- R3: Consecutive strobes inside one waveform are exactly max(`upd_interval`, MIN_UI) cycles apart, where MIN_UI defaults to 40.
- R4: With `iter_en` = 1, a run emits exactly `wave_len` × `iter_count` strobes, and `busy` is 0 in the cycle after the last one.
- R5: `rd_addr` is 0 at the first strobe after each accepted start. It advances by one after every strobe, returns to 0 after `pat_len`−1, and carries on across waveform boundaries.
- R6: With `gap_len` = G > 0, the first strobe of the next waveform comes G+1 cycles after the last strobe of the previous one. With G = 0, it comes one update interval after.
- R7: `wr_stb` is high for one cycle per sample, and `ch_wr` equals `ch_en` in that cycle and is 0 otherwise. `group_upd` is high in the cycle after each strobe when `ch_en` is non-zero, and is never high at any other time.
- R8: `busy` is 0 during the start delay. It is 1 from the cycle of the first strobe until playback terminates, including the gaps.
- R9: A start trigger that arrives during delay, playback or gap is ignored, and it does not count toward the trigger cap.
- R10: With `retrig_en` = 0, only one start is accepted. With `retrig_en` = 1, at most `trig_limit` starts are accepted. In both cases `trig_reset` restores acceptance.
- R11: With `iter_en` = 0, waveforms repeat until a stop trigger arrives.
- R12: Stop mode 0 (and 3) ends playback at once: no strobe after the cycle in which the stop is presented, and `busy` is 0 in the next cycle.
- R13: Stop mode 1 lets the waveform in progress complete and then ends, so the strobe count is a multiple of `wave_len`. In a gap, or between waveforms, it ends at once.
- R14: Stop mode 2 ends once `iter_count` waveforms of the run have completed, even with `iter_en` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock |
| rst | input | 1 | Synchronous active-high reset |
| start_trig | input | 1 | Start trigger |
| stop_trig | input | 1 | Stop trigger |
| stop_mode | input | 2 | 0/3 immediate, 1 finish waveform, 2 finish iterations |
| trig_reset | input | 1 | Clears the accepted-trigger count |
| retrig_en | input | 1 | Allows more than one accepted start |
| trig_limit | input | TRG_W | Maximum accepted starts when retrigger is on |
| upd_interval | input | UI_W | Cycles between samples (clamped to MIN_UI) |
| wave_len | input | UC_W | Samples per waveform |
| iter_count | input | IC_W | Waveforms per run |
| iter_en | input | 1 | Enables ending after iter_count waveforms |
| start_delay | input | DLY_W | Delay-clock ticks before the first sample |
| gap_len | input | DLY_W | Idle cycles between waveforms |
| dly_tick | input | 1 | Enable of the start-delay clock |
| pat_len | input | ADDR_W+1 | Stored pattern length |
| ch_en | input | NCH | Channel enables of the group |
| rd_addr | output | ADDR_W | Pattern memory read address |
| wr_stb | output | 1 | Sample write strobe |
| ch_wr | output | NCH | Per-channel write strobes |
| group_upd | output | 1 | Simultaneous group load pulse |
| busy | output | 1 | Playback in progress |

## Verification
Several properties are checked on every cycle:
- the strobe lasts one cycle;
- strobes inside a waveform are never closer than the minimum interval;
- `busy` only rises together with a strobe;
- an immediate stop drops `busy` at once;
- the read address stays inside the pattern;
- a start is never taken when the trigger gate refuses it.

Exact strobe timing, slice and wrap addressing, gap spacing, the trigger cap with its reset, and the stop modes that finish a waveform or the iterations can only be shown by the bench's scenarios. The scoreboard predicts every strobe's cycle and address from the programmed counters.

// File: rtl/wfg_pkg.sv
package wfg_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DELAY = 3'd1,
        S_RUN   = 3'd2,
        S_GAP   = 3'd3
    } seq_state_e;

    typedef enum logic [1:0] {
        STOP_NOW  = 2'd0,
        STOP_WAVE = 2'd1,
        STOP_ITER = 2'd2
    } stop_kind_e;

    typedef struct packed {
        logic       valid;
        stop_kind_e kind;
    } stop_req_t;

    function automatic stop_kind_e stop_decode(input logic [1:0] mode);
        case (mode)
            2'b01:   return STOP_WAVE;
            2'b10:   return STOP_ITER;
            default: return STOP_NOW;
        endcase
    endfunction

endpackage

// File: rtl/wfg_interval_timer.sv
module wfg_interval_timer #(
    parameter int UI_W   = 24,
    parameter int MIN_UI = 40
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            run,
    input  logic [UI_W-1:0] interval,
    output logic            tick
);
    localparam logic [UI_W-1:0] MIN_V = UI_W'(MIN_UI);

    logic [UI_W-1:0] cnt;
    logic [UI_W-1:0] eff;

    assign eff  = (interval < MIN_V) ? MIN_V : interval;
    assign tick = run && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst || !run)
            cnt <= '0;
        else if (tick)
            cnt <= eff - 1'b1;
        else
            cnt <= cnt - 1'b1;
    end

    // R7: a strobe never lasts longer than one cycle
    assert_tick_single_R7: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

endmodule

// File: rtl/wfg_addr_gen.sv
module wfg_addr_gen #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              advance,
    input  logic [ADDR_W:0]   pat_len,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W:0] nxt;

    assign nxt = {1'b0, addr} + 1'b1;

    always_ff @(posedge clk) begin
        if (rst || restart)
            addr <= '0;
        else if (advance)
            addr <= (nxt >= pat_len) ? '0 : nxt[ADDR_W-1:0];
    end

    // R5: the pointer never leaves the stored pattern
    assert_addr_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (advance && ({1'b0, addr} < pat_len)) |=> ({1'b0, addr} < $past(pat_len)));

endmodule

// File: rtl/wfg_trig_gate.sv
module wfg_trig_gate #(
    parameter int TRG_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             take,
    input  logic             retrig_en,
    input  logic [TRG_W-1:0] limit,
    output logic             ok
);
    logic [TRG_W-1:0] acc;

    assign ok = retrig_en ? (acc < limit) : (acc == '0);

    always_ff @(posedge clk) begin
        if (rst || clear)
            acc <= '0;
        else if (take && (acc != '1))
            acc <= acc + 1'b1;
    end

    // R10: the sequencer only takes a start that the gate allows
    assert_take_allowed_R10: assert property (@(posedge clk) disable iff (rst)
        take |-> ok);

endmodule

// File: rtl/wfg_seq.sv
module wfg_seq
    import wfg_pkg::*;
#(
    parameter int UI_W   = 24,
    parameter int UC_W   = 24,
    parameter int IC_W   = 16,
    parameter int DLY_W  = 16,
    parameter int TRG_W  = 16,
    parameter int ADDR_W = 10,
    parameter int NCH    = 4,
    parameter int MIN_UI = 40
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_trig,
    input  logic              stop_trig,
    input  logic [1:0]        stop_mode,
    input  logic              trig_reset,
    input  logic              retrig_en,
    input  logic [TRG_W-1:0]  trig_limit,
    input  logic [UI_W-1:0]   upd_interval,
    input  logic [UC_W-1:0]   wave_len,
    input  logic [IC_W-1:0]   iter_count,
    input  logic              iter_en,
    input  logic [DLY_W-1:0]  start_delay,
    input  logic [DLY_W-1:0]  gap_len,
    input  logic              dly_tick,
    input  logic [ADDR_W:0]   pat_len,
    input  logic [NCH-1:0]    ch_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic [NCH-1:0]    ch_wr,
    output logic              group_upd,
    output logic              busy
);
    localparam logic [DLY_W-1:0] DLY_ONE = DLY_W'(1);

    seq_state_e      state, nstate;
    stop_req_t       pend_q, pend_eff;
    logic            tick, gate_ok, take, halt_now;
    logic            wave_end, end_run, met_next, met_now;
    logic [UC_W-1:0] samp_cnt;
    logic [IC_W-1:0] iter_cnt, iter_next;
    logic [DLY_W-1:0] dcnt, gcnt;

    wfg_interval_timer #(.UI_W(UI_W), .MIN_UI(MIN_UI)) u_timer (
        .clk(clk), .rst(rst), .run(state == S_RUN),
        .interval(upd_interval), .tick(tick)
    );

    wfg_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk(clk), .rst(rst), .restart(take), .advance(wr_stb),
        .pat_len(pat_len), .addr(rd_addr)
    );

    wfg_trig_gate #(.TRG_W(TRG_W)) u_gate (
        .clk(clk), .rst(rst), .clear(trig_reset), .take(take),
        .retrig_en(retrig_en), .limit(trig_limit), .ok(gate_ok)
    );

    assign wr_stb    = (state == S_RUN) && tick;
    assign busy      = (state == S_RUN) || (state == S_GAP);
    assign wave_end  = ({1'b0, samp_cnt} + 1'b1) >= {1'b0, wave_len};
    assign iter_next = (iter_cnt == '1) ? iter_cnt : iter_cnt + 1'b1;
    assign met_next  = iter_next >= iter_count;
    assign met_now   = iter_cnt >= iter_count;
    assign halt_now  = stop_trig && (stop_decode(stop_mode) == STOP_NOW);

    always_comb begin
        pend_eff = pend_q;
        if (stop_trig) begin
            pend_eff.valid = 1'b1;
            pend_eff.kind  = stop_decode(stop_mode);
        end
    end

    assign end_run = (iter_en && met_next)
                   || (pend_eff.valid && pend_eff.kind == STOP_WAVE)
                   || (pend_eff.valid && pend_eff.kind == STOP_ITER && met_next);

    always_comb begin
        nstate = state;
        take   = 1'b0;
        case (state)
            S_IDLE: begin
                if (start_trig && gate_ok) begin
                    take   = 1'b1;
                    nstate = (start_delay == '0) ? S_RUN : S_DELAY;
                end
            end
            S_DELAY: begin
                if (stop_trig)
                    nstate = S_IDLE;
                else if (dly_tick && dcnt == DLY_ONE)
                    nstate = S_RUN;
            end
            S_RUN: begin
                if (halt_now)
                    nstate = S_IDLE;
                else if (tick && wave_end)
                    nstate = end_run ? S_IDLE : ((gap_len != '0) ? S_GAP : S_RUN);
                else if (!tick && samp_cnt == '0 && pend_eff.valid &&
                         (pend_eff.kind == STOP_WAVE || (pend_eff.kind == STOP_ITER && met_now)))
                    nstate = S_IDLE;
            end
            S_GAP: begin
                if (halt_now)
                    nstate = S_IDLE;
                else if (pend_eff.valid &&
                         (pend_eff.kind == STOP_WAVE || (pend_eff.kind == STOP_ITER && met_now)))
                    nstate = S_IDLE;
                else if (gcnt == DLY_ONE)
                    nstate = S_RUN;
            end
            default: nstate = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= S_IDLE;
            pend_q    <= '0;
            dcnt      <= '0;
            gcnt      <= '0;
            samp_cnt  <= '0;
            iter_cnt  <= '0;
            group_upd <= 1'b0;
        end else begin
            state     <= nstate;
            group_upd <= wr_stb && (ch_en != '0);
            if (nstate == S_IDLE || take)
                pend_q <= '0;
            else if (stop_trig && busy)
                pend_q <= pend_eff;
            if (take)
                dcnt <= start_delay;
            else if (state == S_DELAY && dly_tick)
                dcnt <= dcnt - 1'b1;
            if (state == S_RUN && nstate == S_GAP)
                gcnt <= gap_len;
            else if (state == S_GAP)
                gcnt <= gcnt - 1'b1;
            if (take) begin
                samp_cnt <= '0;
                iter_cnt <= '0;
            end else if (wr_stb) begin
                samp_cnt <= wave_end ? '0 : samp_cnt + 1'b1;
                if (wave_end)
                    iter_cnt <= iter_next;
            end
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        assign ch_wr[g] = wr_stb && ch_en[g];
    end

    // checker: cycles since the previous strobe
    int since_stb;
    always_ff @(posedge clk) begin
        if (rst)
            since_stb <= 0;
        else if (wr_stb)
            since_stb <= 1;
        else if (since_stb < 1_000_000)
            since_stb <= since_stb + 1;
    end

    // R3: strobes inside one waveform respect the minimum interval
    assert_min_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && samp_cnt != '0) |-> (since_stb >= MIN_UI));

    // R8: busy rises only together with the first strobe
    assert_busy_with_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> wr_stb);

    // R12: an immediate stop ends playback in the next cycle
    assert_stop_now_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && stop_trig && stop_mode == 2'b00) |=> (!busy && !wr_stb));

endmodule

// File: tb/wfg_seq_bench.sv
module wfg_seq_bench;
    localparam int AW  = 10;
    localparam int NCH = 4;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic           rst, start_trig, stop_trig, trig_reset, retrig_en, iter_en, dly_tick;
    logic [1:0]     stop_mode;
    logic [15:0]    trig_limit, iter_count, start_delay, gap_len;
    logic [23:0]    upd_interval, wave_len;
    logic [AW:0]    pat_len;
    logic [NCH-1:0] ch_en;
    logic [AW-1:0]  rd_addr;
    logic           wr_stb, group_upd, busy;
    logic [NCH-1:0] ch_wr;

    wfg_seq u_wfg_seq (
        .clk(clk), .rst(rst), .start_trig(start_trig), .stop_trig(stop_trig),
        .stop_mode(stop_mode), .trig_reset(trig_reset), .retrig_en(retrig_en),
        .trig_limit(trig_limit), .upd_interval(upd_interval), .wave_len(wave_len),
        .iter_count(iter_count), .iter_en(iter_en), .start_delay(start_delay),
        .gap_len(gap_len), .dly_tick(dly_tick), .pat_len(pat_len), .ch_en(ch_en),
        .rd_addr(rd_addr), .wr_stb(wr_stb), .ch_wr(ch_wr), .group_upd(group_upd),
        .busy(busy)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int c;
        int a;
        int w;
        bit fin;
    } item_t;

    item_t exp_q[$];
    item_t cur;
    int    n_chk = 0, n_fail = 0;
    int    last_wave = -1;
    bit    expect_idle = 0;
    bit    prev_stb = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (expect_idle) begin
                check(!busy, "R4", "busy after final strobe", busy, 0);
                expect_idle = 0;
            end
            if (group_upd || prev_stb)
                check(group_upd == (prev_stb && ch_en != 0), "R7", "group update pulse",
                      group_upd, prev_stb && ch_en != 0);
            if (wr_stb) begin
                if (exp_q.size() == 0) begin
                    check(0, "R9", "unexpected strobe at cycle", cyc, -1);
                end else begin
                    cur = exp_q.pop_front();
                    check(cyc == cur.c, "R2 R3 R6", "strobe cycle", cyc, cur.c);
                    check(int'(rd_addr) == cur.a, "R5", "read address", int'(rd_addr), cur.a);
                    check(busy, "R8", "busy at strobe", busy, 1);
                    check(ch_wr == ch_en, "R7", "channel strobes", int'(ch_wr), int'(ch_en));
                    last_wave = cur.w;
                    if (cur.fin) expect_idle = 1;
                end
            end else if (ch_wr != 0) begin
                check(0, "R7", "channel strobe without write strobe", int'(ch_wr), 0);
            end
            prev_stb = wr_stb;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic plan(input int t0, input int f_off, input int ival, input int cnt,
                        input int waves, input int gap, input int plen);
        int c  = t0 + f_off;
        int a  = 0;
        int ie = (ival < 40) ? 40 : ival;
        for (int w = 0; w < waves; w++) begin
            for (int k = 0; k < cnt; k++) begin
                item_t it;
                it.c = c; it.a = a; it.w = w; it.fin = 0;
                exp_q.push_back(it);
                a = (a + 1 >= plen) ? 0 : a + 1;
                if (k < cnt - 1) c += ie;
            end
            c += (gap == 0) ? ie : gap + 1;
        end
        exp_q[$].fin = 1;
    endtask

    task automatic fire_start();
        start_trig = 1'b1;
        step(1);
        start_trig = 1'b0;
    endtask

    task automatic pulse_stop(input logic [1:0] mode);
        stop_mode = mode;
        stop_trig = 1'b1;
        if (mode == 2'b00 || mode == 2'b11) begin
            exp_q.delete();
        end else if (mode == 2'b01) begin
            while (exp_q.size() > 0 && exp_q[$].w > last_wave) void'(exp_q.pop_back());
        end else begin
            while (exp_q.size() > 0 && exp_q[$].w >= int'(iter_count)) void'(exp_q.pop_back());
        end
        if (exp_q.size() > 0) exp_q[$].fin = 1;
        step(1);
        stop_trig = 1'b0;
    endtask

    task automatic pulse_trig_reset();
        trig_reset = 1'b1;
        step(1);
        trig_reset = 1'b0;
    endtask

    task automatic wait_done(input int limit);
        int n = 0;
        while (exp_q.size() != 0 && n < limit) begin
            step(1);
            n++;
        end
        if (exp_q.size() != 0) begin
            check(0, "R4", "missing strobes", exp_q.size(), 0);
            exp_q.delete();
        end
        step(2);
        check(busy == 0, "R4", "busy after run", busy, 0);
    endtask

    bit done = 0;

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int t;
        rst = 1'b1; start_trig = 0; stop_trig = 0; stop_mode = 2'b00; trig_reset = 0;
        retrig_en = 0; trig_limit = 0; upd_interval = 40; wave_len = 1; iter_count = 1;
        iter_en = 1; start_delay = 0; gap_len = 0; dly_tick = 1; pat_len = 4; ch_en = 4'b0101;
        step(3);
        // R1: reset state
        check(wr_stb == 0 && ch_wr == 0, "R1", "strobes in reset", wr_stb, 0);
        check(busy == 0, "R1", "busy in reset", busy, 0);
        check(group_upd == 0, "R1", "group update in reset", group_upd, 0);
        check(rd_addr == 0, "R1", "address in reset", int'(rd_addr), 0);
        rst = 1'b0;
        step(5);
        check(busy == 0 && wr_stb == 0, "R1", "idle after reset", busy, 0);

        // delay, clamped interval, gap, two iterations (R2 R3 R4 R6 R8)
        start_delay = 3; upd_interval = 3; wave_len = 3; iter_count = 2; iter_en = 1;
        gap_len = 5; pat_len = 4;
        plan(cyc + 1, 3, 3, 3, 2, 5, 4);
        fire_start();
        check(busy == 0, "R8", "busy during start delay", busy, 0);
        wait_done(400);

        // R10: no retrigger, second start refused
        fire_start();
        step(60);
        check(busy == 0, "R10", "second start without retrigger", busy, 0);

        pulse_trig_reset();
        retrig_en = 1; trig_limit = 2;

        // wrap through short pattern, gap 0, start during playback ignored (R5 R6 R9)
        start_delay = 0; upd_interval = 45; wave_len = 5; iter_count = 2; gap_len = 0;
        pat_len = 3; ch_en = 4'b1111;
        plan(cyc + 1, 0, 45, 5, 2, 0, 3);
        fire_start();
        step(100);
        fire_start(); // R9: ignored and not counted
        wait_done(600);

        // iteration disabled, finish-waveform stop (R11 R13)
        iter_en = 0; iter_count = 1; start_delay = 1; upd_interval = 40; wave_len = 4;
        gap_len = 2; pat_len = 16; ch_en = 4'b0000; last_wave = -1;
        t = cyc + 1;
        plan(t, 1, 40, 4, 5, 2, 16);
        fire_start();
        step(130);
        check(busy == 1, "R11", "still running past iteration count", busy, 1);
        while (cyc < t + 170) step(1);
        pulse_stop(2'b01);
        wait_done(400);

        // R10: third start refused at limit 2
        fire_start();
        step(60);
        check(busy == 0, "R10", "start beyond trigger cap", busy, 0);
        pulse_trig_reset();

        // R14: finish programmed iterations with counter disabled
        iter_en = 0; iter_count = 3; start_delay = 0; upd_interval = 40; wave_len = 2;
        gap_len = 0; pat_len = 5; ch_en = 4'b0011;
        plan(cyc + 1, 0, 40, 2, 6, 0, 5);
        fire_start();
        step(30);
        pulse_stop(2'b10);
        wait_done(600);

        // R12: immediate stop
        iter_en = 1; iter_count = 4; wave_len = 3; upd_interval = 50; gap_len = 0;
        t = cyc + 1;
        plan(t, 0, 50, 3, 4, 0, 5);
        fire_start();
        while (cyc < t + 70) step(1);
        pulse_stop(2'b00);
        check(busy == 0, "R12", "busy after immediate stop", busy, 0);
        step(200);
        check(busy == 0 && exp_q.size() == 0, "R12", "no playback after stop", busy, 0);
        pulse_trig_reset();

        // R2: only delay-clock ticks count
        dly_tick = 0; start_delay = 2; iter_en = 1; iter_count = 1; wave_len = 2;
        upd_interval = 40; gap_len = 0; pat_len = 8;
        plan(cyc + 1, 12, 40, 2, 1, 0, 8);
        fire_start();
        step(5);
        check(busy == 0, "R8", "busy while delay clock idle", busy, 0);
        step(5);
        dly_tick = 1;
        wait_done(200);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule